// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block is the local interrupt interface owned by one processor in a multiprocessor interrupt controller. It holds this processor's enable bit for every interrupt ID, the trigger mode of the 32 private IDs (0 to 31), and an active flag per ID. Shared IDs (32 and up) arrive as pending levels from the distributor. Private IDs arrive as raw lines and are qualified here by level or by edge.

Software enables or disables an ID by writing its number to a set-enable or a clear-enable register. It takes an interrupt by reading the ready register, which returns the lowest-numbered enabled, pending, non-active ID and marks it active. It finishes the interrupt by writing the same number to the completion register. A single request line to the core is raised while any ID could be taken. The register window is 0x1000 bytes. Each processor's window sits 0x1000 above the previous one, and the first window starts 0x8000 above the distributor base. That placement is decoded outside this block.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset the control bit, all enables, all active flags and both trigger words are zero. `irq_req` is low, and a ready read returns 0xFFFFFFFF.
- R2: Bit 0 of the control register at offset 0x000 switches the interface on and reads back. While it is 0, `irq_req` stays low, and a ready read returns 0xFFFFFFFF and claims nothing.
- R3: A write of an ID to offset 0x0A0 sets that ID's enable, and a write to offset 0x0A4 clears it. A value of NUM_IDS or more has no effect on any enable.
- R4: Private trigger modes are 2-bit fields, 16 to a word. The word at 0x014 holds IDs 0 to 15 and the word at 0x018 holds IDs 16 to 31. The field for ID n sits at bits 2*(n%16)+1 : 2*(n%16). The codes are 0 for level high, 1 for level low, 2 for rising edge and 3 for falling edge. Both words read back.
- R5: A level-mode private ID is pending while its line is at the selected level. Shared ID n is pending while `shared_pend[n-32]` is high.
- R6: An edge-mode private ID is latched pending at the clock edge where the line is seen at the new value while the previous sample held the old one. It stays pending after the line returns, until it is claimed.
- R7: A read of offset 0x06C is answered one cycle later with `rsp_valid` high. The answer is the lowest enabled, pending, non-active ID, and that ID becomes active at the same edge. If no ID qualifies, the answer is 0xFFFFFFFF and no state changes.
- R8: An active ID is neither returned by a ready read nor counted for `irq_req` until its number is written to offset 0x0B4. That write clears its active flag.
- R9: A completion write for an ID that is not active, or is out of range, changes nothing.
- R10: `irq_req` is high exactly when the interface is on and some ID is enabled, pending and not active. It follows level inputs in the same cycle, and register state from the edge at which that state was written.
- R11: Reads of any other offset return zero. Writes to the ready register or to unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| priv_line | input | 32 | Raw lines of private IDs 0 to 31 |
| shared_pend | input | NUM_IDS-32 | Pending levels of shared IDs 32 and up |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
A read's data and the claim it makes are due one clock edge after the read is accepted. The bench drives each access before a rising edge and samples `rsp_valid` and `rsp_rdata` at the following falling edge. `irq_req` is compared at every falling edge. It must already reflect the register writes and edge latches of the preceding rising edge, together with the level inputs currently driven. A reference model in the bench is stepped once per rising edge, using the pre-edge state, so that each expected value belongs to the cycle in which it is sampled.

// File: rtl/cpu_irq_port_pkg.sv
// Package: shared offsets, trigger codes and access decode for the
// per-CPU interrupt interface. Assumes a 12-bit byte offset window.
package cpu_irq_port_pkg;

    localparam int unsigned PRIV_IDS = 32;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFS_CTL    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_TRIG_A = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_TRIG_B = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_READY  = 12'h06C;
    localparam logic [ADDR_W-1:0] OFS_SET_EN = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_CLR_EN = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_DONE   = 12'h0B4;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_mode_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CTL,
        OP_TRIG_A,
        OP_TRIG_B,
        OP_READY,
        OP_SET_EN,
        OP_CLR_EN,
        OP_DONE
    } reg_op_e;

    // Map a byte offset onto the register it selects.
    function automatic reg_op_e decode_op(input logic [ADDR_W-1:0] addr);
        case (addr)
            OFS_CTL:    return OP_CTL;
            OFS_TRIG_A: return OP_TRIG_A;
            OFS_TRIG_B: return OP_TRIG_B;
            OFS_READY:  return OP_READY;
            OFS_SET_EN: return OP_SET_EN;
            OFS_CLR_EN: return OP_CLR_EN;
            OFS_DONE:   return OP_DONE;
            default:    return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cpu_irq_regs.sv
// Configuration registers: interface switch, private trigger words and the
// per-ID enable vector. Assumes writes arrive already decoded, one per cycle.
module cpu_irq_regs
    import cpu_irq_port_pkg::*;
#(
    parameter int unsigned NUM_IDS = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  reg_op_e               wr_op,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  ctl_en,
    output logic [2*PRIV_IDS-1:0] trig_cfg,
    output logic [NUM_IDS-1:0]    id_en
);
    localparam int unsigned ID_W = $clog2(NUM_IDS);

    logic            id_ok;
    logic [ID_W-1:0] id_idx;

    assign id_ok  = (wr_data < DATA_W'(NUM_IDS));
    assign id_idx = wr_data[ID_W-1:0];

    // Interface switch and trigger words take whole-field writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            trig_cfg <= '0;
        end else if (wr_en) begin
            case (wr_op)
                OP_CTL:    ctl_en <= wr_data[0];
                OP_TRIG_A: trig_cfg[DATA_W-1:0] <= wr_data;
                OP_TRIG_B: trig_cfg[2*DATA_W-1:DATA_W] <= wr_data;
                default:   ;
            endcase
        end
    end

    // Enable bits change one ID at a time by number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_en <= '0;
        end else if (wr_en && id_ok) begin
            if (wr_op == OP_SET_EN) id_en[id_idx] <= 1'b1;
            else if (wr_op == OP_CLR_EN) id_en[id_idx] <= 1'b0;
        end
    end

endmodule

// File: rtl/cpu_irq_pend.sv
// Pending qualification: private lines by level or latched edge, shared IDs
// passed through as levels. Assumes private lines are already synchronous.
module cpu_irq_pend
    import cpu_irq_port_pkg::*;
#(
    parameter int unsigned NUM_IDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2*PRIV_IDS-1:0]        trig_cfg,
    input  logic [PRIV_IDS-1:0]          priv_line,
    input  logic [NUM_IDS-PRIV_IDS-1:0]  shared_pend,
    input  logic                         claim_valid,
    input  logic [$clog2(NUM_IDS)-1:0]   claim_id,
    output logic [NUM_IDS-1:0]           pend
);
    localparam int unsigned ID_W = $clog2(NUM_IDS);

    logic [PRIV_IDS-1:0] line_prev;

    // Previous sample of every private line; loaded during reset so that a
    // line already high does not look like an edge.
    always_ff @(posedge clk) begin
        line_prev <= priv_line;
    end

    for (genvar g = 0; g < PRIV_IDS; g++) begin : g_priv
        trig_mode_e mode;
        logic       rise;
        logic       fall;
        logic       edge_q;

        assign mode = trig_mode_e'(trig_cfg[2*g +: 2]);
        assign rise = priv_line[g] & ~line_prev[g];
        assign fall = ~priv_line[g] & line_prev[g];

        // Edge latch: a new edge wins over a claim in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                edge_q <= 1'b0;
            end else if ((mode == TRIG_RISE && rise) || (mode == TRIG_FALL && fall)) begin
                edge_q <= 1'b1;
            end else if (mode == TRIG_LVL_HI || mode == TRIG_LVL_LO) begin
                edge_q <= 1'b0;
            end else if (claim_valid && claim_id == ID_W'(g)) begin
                edge_q <= 1'b0;
            end
        end

        assign pend[g] = (mode == TRIG_LVL_HI) ?  priv_line[g] :
                         (mode == TRIG_LVL_LO) ? ~priv_line[g] : edge_q;
    end

    assign pend[NUM_IDS-1:PRIV_IDS] = shared_pend;

endmodule

// File: rtl/cpu_irq_pick.sv
// Fixed-priority finder: lowest set bit of the request vector wins.
// Assumes a purely combinational path is acceptable for NUM_IDS requests.
module cpu_irq_pick #(
    parameter int unsigned NUM_IDS = 64
) (
    input  logic [NUM_IDS-1:0]         req,
    output logic                       found,
    output logic [$clog2(NUM_IDS)-1:0] win_id
);
    localparam int unsigned ID_W = $clog2(NUM_IDS);

    // Scan from the top down so the lowest index is written last.
    always_comb begin
        found  = 1'b0;
        win_id = '0;
        for (int i = NUM_IDS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found  = 1'b1;
                win_id = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/cpu_irq_port.sv
// Per-CPU interrupt interface top: register decode, claim/complete tracking,
// read response and the request line to the core. Assumes one access per
// cycle and read data consumed one cycle after the read.
module cpu_irq_port
    import cpu_irq_port_pkg::*;
#(
    parameter int unsigned NUM_IDS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [11:0]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic                        rsp_valid,
    output logic [31:0]                 rsp_rdata,
    input  logic [31:0]                 priv_line,
    input  logic [NUM_IDS-33:0]         shared_pend,
    output logic                        irq_req
);
    localparam int unsigned ID_W = $clog2(NUM_IDS);

    reg_op_e               op;
    logic                  wr_en;
    logic                  rd_en;
    logic                  ctl_en;
    logic [2*PRIV_IDS-1:0] trig_cfg;
    logic [NUM_IDS-1:0]    id_en;
    logic [NUM_IDS-1:0]    pend;
    logic [NUM_IDS-1:0]    active_q;
    logic [NUM_IDS-1:0]    eligible;
    logic                  found;
    logic [ID_W-1:0]       win_id;
    logic                  claim_valid;
    logic                  done_hit;
    logic [ID_W-1:0]       done_idx;
    logic [DATA_W-1:0]     rd_next;

    assign op    = decode_op(bus_addr);
    assign wr_en = bus_valid & bus_write;
    assign rd_en = bus_valid & ~bus_write;

    cpu_irq_regs #(.NUM_IDS(NUM_IDS)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_op    (op),
        .wr_data  (bus_wdata),
        .ctl_en   (ctl_en),
        .trig_cfg (trig_cfg),
        .id_en    (id_en)
    );

    cpu_irq_pend #(.NUM_IDS(NUM_IDS)) pend_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_cfg    (trig_cfg),
        .priv_line   (priv_line),
        .shared_pend (shared_pend),
        .claim_valid (claim_valid),
        .claim_id    (win_id),
        .pend        (pend)
    );

    assign eligible = pend & id_en & ~active_q;

    cpu_irq_pick #(.NUM_IDS(NUM_IDS)) pick_i (
        .req    (eligible),
        .found  (found),
        .win_id (win_id)
    );

    assign claim_valid = rd_en && (op == OP_READY) && ctl_en && found;
    assign done_idx    = bus_wdata[ID_W-1:0];
    assign done_hit    = wr_en && (op == OP_DONE) &&
                         (bus_wdata < DATA_W'(NUM_IDS)) && active_q[done_idx];

    // Active flags: set by a claiming read, cleared by a matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (claim_valid) begin
            active_q[win_id] <= 1'b1;
        end else if (done_hit) begin
            active_q[done_idx] <= 1'b0;
        end
    end

    // Read multiplexer for the response register.
    always_comb begin
        case (op)
            OP_CTL:    rd_next = {{(DATA_W-1){1'b0}}, ctl_en};
            OP_TRIG_A: rd_next = trig_cfg[DATA_W-1:0];
            OP_TRIG_B: rd_next = trig_cfg[2*DATA_W-1:DATA_W];
            OP_READY:  rd_next = (ctl_en && found) ? DATA_W'(win_id) : '1;
            default:   rd_next = '0;
        endcase
    end

    // Registered read response, one cycle after the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_rdata <= rd_next;
        end
    end

    assign irq_req = ctl_en & (|eligible);

endmodule

// File: rtl/cpu_irq_port_chk.sv
// Checker for cpu_irq_port: temporal properties on the bus response, the
// claim/complete bookkeeping and the request line. Bound to every instance.
module cpu_irq_port_chk
    import cpu_irq_port_pkg::*;
#(
    parameter int unsigned NUM_IDS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               rsp_valid,
    input logic [31:0]        rsp_rdata,
    input logic               irq_req,
    input logic               ctl_en,
    input logic [NUM_IDS-1:0] active_q
);
    localparam int unsigned ID_W = $clog2(NUM_IDS);

    logic ready_rd;
    logic done_wr;
    logic done_miss;

    assign ready_rd  = bus_valid && !bus_write && bus_addr == OFS_READY;
    assign done_wr   = bus_valid && bus_write && bus_addr == OFS_DONE &&
                       bus_wdata < 32'(NUM_IDS);
    assign done_miss = bus_valid && bus_write && bus_addr == OFS_DONE &&
                       (bus_wdata >= 32'(NUM_IDS) || !active_q[bus_wdata[ID_W-1:0]]);

    // R1: a reset cycle leaves the switch off and nothing active.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!ctl_en && active_q == '0));

    // R2: the request line is quiet while the interface is switched off.
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !irq_req);

    // R2: a ready read with the interface off answers empty and claims nothing.
    p_off_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_rd && !ctl_en) |=> (rsp_rdata == '1 && $stable(active_q)));

    // R7: every read gets its response on the next cycle, and only reads do.
    p_rsp_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rsp_valid);
    p_rsp_only_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rsp_valid);

    // R7: a returned ID is active; an empty answer leaves the flags alone.
    p_claim_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_rd |=> (rsp_rdata == '1 || active_q[rsp_rdata[ID_W-1:0]]));
    p_empty_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_rd |=> (rsp_rdata != '1 || $stable(active_q)));

    // R8: a completion write clears the named ID.
    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_wr |=> !active_q[$past(bus_wdata[ID_W-1:0])]);

    // R9: completion of a non-active or out-of-range ID changes nothing.
    p_done_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_miss |=> $stable(active_q));

    // R8: at most one active flag appears per cycle.
    p_one_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_q & ~$past(active_q)) <= 1);

endmodule

bind cpu_irq_port cpu_irq_port_chk #(.NUM_IDS(NUM_IDS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq_req   (irq_req),
    .ctl_en    (ctl_en),
    .active_q  (active_q)
);

// File: tb/cpu_irq_port_tb_top.sv
// Bench for cpu_irq_port: directed corner cases, then seeded random traffic,
// all compared against a cycle-stepped reference model kept in the bench.
module cpu_irq_port_tb_top;

    localparam int  NUM        = 64;
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_valid;
    logic          bus_write;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [31:0]   priv_line;
    logic [NUM-33:0] shared_pend;
    logic          irq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    logic            m_ctl;
    logic [63:0]     m_trig;
    logic [NUM-1:0]  m_en;
    logic [NUM-1:0]  m_act;
    logic [31:0]     m_latch;
    logic [31:0]     m_prev;
    logic            exp_valid;
    logic [31:0]     exp_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_irq_port #(.NUM_IDS(NUM)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .priv_line   (priv_line),
        .shared_pend (shared_pend),
        .irq_req     (irq_req)
    );

    function automatic logic [NUM-1:0] m_pend();
        logic [NUM-1:0] p;
        for (int i = 0; i < 32; i++) begin
            case (m_trig[2*i +: 2])
                2'd0:    p[i] = priv_line[i];
                2'd1:    p[i] = ~priv_line[i];
                default: p[i] = m_latch[i];
            endcase
        end
        for (int i = 32; i < NUM; i++) p[i] = shared_pend[i-32];
        return p;
    endfunction

    function automatic logic m_irq();
        return m_ctl && (|(m_pend() & m_en & ~m_act));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Step the model across one rising edge using pre-edge state.
    task automatic model_edge(input logic v, input logic wr, input logic [11:0] a,
                              input logic [31:0] d);
        logic [NUM-1:0] elig;
        logic [31:0]    rd;
        int             win;
        logic           claim;
        elig = m_pend() & m_en & ~m_act;
        win = -1;
        for (int i = NUM - 1; i >= 0; i--) if (elig[i]) win = i;
        claim = v && !wr && a == 12'h06C && m_ctl && win >= 0;
        case (a)
            12'h000: rd = {31'b0, m_ctl};
            12'h014: rd = m_trig[31:0];
            12'h018: rd = m_trig[63:32];
            12'h06C: rd = (m_ctl && win >= 0) ? win : 32'hFFFF_FFFF;
            default: rd = 32'h0;
        endcase
        for (int i = 0; i < 32; i++) begin
            logic [1:0] md;
            md = m_trig[2*i +: 2];
            if ((md == 2'd2 && priv_line[i] && !m_prev[i]) ||
                (md == 2'd3 && !priv_line[i] && m_prev[i]))
                m_latch[i] = 1'b1;
            else if (md < 2'd2)
                m_latch[i] = 1'b0;
            else if (claim && win == i)
                m_latch[i] = 1'b0;
        end
        m_prev = priv_line;
        if (claim) m_act[win] = 1'b1;
        if (v && wr) begin
            case (a)
                12'h000: m_ctl = d[0];
                12'h014: m_trig[31:0] = d;
                12'h018: m_trig[63:32] = d;
                12'h0A0: if (d < NUM) m_en[d] = 1'b1;
                12'h0A4: if (d < NUM) m_en[d] = 1'b0;
                12'h0B4: if (d < NUM && m_act[d]) m_act[d] = 1'b0;
                default: ;
            endcase
        end
        exp_valid = v && !wr;
        if (exp_valid) exp_rdata = rd;
    endtask

    // One bus cycle, entered and left at a falling edge.
    task automatic do_op(input logic v, input logic wr, input logic [11:0] a,
                         input logic [31:0] d, input string tag);
        bus_valid = v;
        bus_write = wr;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        model_edge(v, wr, a, d);
        @(negedge clk);
        bus_valid = 1'b0;
        chk({tag, " rsp_valid R7"}, {31'b0, rsp_valid}, {31'b0, exp_valid});
        if (exp_valid) chk(tag, rsp_rdata, exp_rdata);
        chk("R10 irq_req", {31'b0, irq_req}, {31'b0, m_irq()});
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input string tag);
        do_op(1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd_reg(input logic [11:0] a, input string tag);
        do_op(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic idle(input string tag);
        do_op(1'b0, 1'b0, 12'h0, 32'h0, tag);
    endtask

    function automatic logic [31:0] rand_id();
        int r;
        r = $urandom % 20;
        if (r < 8) return r;
        if (r < 16) return 32 + (r - 8);
        return 64 + r;
    endfunction

    // Watchdog: a hung run ends as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
        priv_line = '0; shared_pend = '0;
        m_ctl = 1'b0; m_trig = '0; m_en = '0; m_act = '0; m_latch = '0; m_prev = '0;
        exp_valid = 1'b0; exp_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq after reset", {31'b0, irq_req}, 32'h0);
        chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        rd_reg(12'h06C, "R1 ready empty");
        chk("R1 ready literal", rsp_rdata, 32'hFFFF_FFFF);
        rd_reg(12'h014, "R1 trig word A");
        chk("R1 trig A literal", rsp_rdata, 32'h0);

        // R2: switch on and read back
        wr_reg(12'h000, 32'h1, "R2 ctl write");
        rd_reg(12'h000, "R2 ctl readback");
        chk("R2 ctl literal", rsp_rdata, 32'h1);

        // R3/R5/R10: shared ID 40 enabled and pending raises the request
        shared_pend[8] = 1'b1;
        idle("R5 pending not enabled");
        chk("R3 irq low before enable", {31'b0, irq_req}, 32'h0);
        wr_reg(12'h0A0, 32'd40, "R3 set enable 40");
        chk("R5 irq from shared 40", {31'b0, irq_req}, 32'h1);

        // R7/R8: claim 40, request drops
        rd_reg(12'h06C, "R7 claim 40");
        chk("R7 claim literal", rsp_rdata, 32'd40);
        chk("R8 irq masked by active", {31'b0, irq_req}, 32'h0);
        rd_reg(12'h06C, "R8 active not offered");
        chk("R8 empty literal", rsp_rdata, 32'hFFFF_FFFF);

        // R9: completing a non-active ID changes nothing
        wr_reg(12'h0B4, 32'd41, "R9 complete 41");
        wr_reg(12'h0B4, 32'd100, "R9 complete out of range");
        chk("R9 irq still low", {31'b0, irq_req}, 32'h0);

        // R8: completing 40 makes it eligible again
        wr_reg(12'h0B4, 32'd40, "R8 complete 40");
        chk("R8 irq back", {31'b0, irq_req}, 32'h1);

        // R7: lowest ID wins
        shared_pend[3] = 1'b1;
        wr_reg(12'h0A0, 32'd35, "R3 set enable 35");
        rd_reg(12'h06C, "R7 lowest first");
        chk("R7 lowest literal", rsp_rdata, 32'd35);
        wr_reg(12'h0B4, 32'd35, "R8 complete 35");

        // R3: clear enable and out-of-range set
        wr_reg(12'h0A4, 32'd40, "R3 clear 40");
        wr_reg(12'h0A4, 32'd35, "R3 clear 35");
        chk("R3 irq low after clears", {31'b0, irq_req}, 32'h0);
        priv_line[0] = 1'b1;
        wr_reg(12'h0A0, 32'd64, "R3 set out of range");
        chk("R3 out of range ignored", {31'b0, irq_req}, 32'h0);
        priv_line[0] = 1'b0;

        // R4/R6: ID 3 rising edge, ID 20 level low
        wr_reg(12'h014, 32'h0000_0080, "R4 trig A write");
        wr_reg(12'h018, 32'h0000_0100, "R4 trig B write");
        rd_reg(12'h018, "R4 trig B readback");
        chk("R4 trig B literal", rsp_rdata, 32'h0000_0100);
        wr_reg(12'h0A0, 32'd3, "R3 set enable 3");
        priv_line[3] = 1'b1;
        idle("R6 edge seen");
        chk("R6 edge latched", {31'b0, irq_req}, 32'h1);
        priv_line[3] = 1'b0;
        idle("R6 line back low");
        chk("R6 edge held", {31'b0, irq_req}, 32'h1);
        rd_reg(12'h06C, "R6 claim edge");
        chk("R6 claim literal", rsp_rdata, 32'd3);
        wr_reg(12'h0B4, 32'd3, "R8 complete 3");
        chk("R6 edge consumed", {31'b0, irq_req}, 32'h0);
        wr_reg(12'h0A0, 32'd20, "R5 enable level-low 20");
        chk("R5 level low pending", {31'b0, irq_req}, 32'h1);
        wr_reg(12'h0A4, 32'd20, "R3 clear 20");

        // R11: unused offset and write to ready
        wr_reg(12'h06C, 32'd7, "R11 write ready ignored");
        rd_reg(12'h0A0, "R11 unused read");
        chk("R11 unused literal", rsp_rdata, 32'h0);

        // R2: switched off
        wr_reg(12'h0A0, 32'd40, "R3 re-enable 40");
        wr_reg(12'h000, 32'h0, "R2 ctl off");
        chk("R2 irq off", {31'b0, irq_req}, 32'h0);
        rd_reg(12'h06C, "R2 ready while off");
        chk("R2 off literal", rsp_rdata, 32'hFFFF_FFFF);
        wr_reg(12'h000, 32'h1, "R2 ctl on");
        rd_reg(12'h06C, "R2 nothing claimed while off");
        chk("R2 claim after on", rsp_rdata, 32'd40);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 4 == 0) priv_line[$urandom % 8] ^= 1'b1;
            if ($urandom % 5 == 0) shared_pend[$urandom % 8] ^= 1'b1;
            case ($urandom % 8)
                0: wr_reg(12'h0A0, rand_id(), "R3 rnd set");
                1: wr_reg(12'h0A4, rand_id(), "R3 rnd clear");
                2: rd_reg(12'h06C, "R7 rnd ready");
                3: wr_reg(12'h0B4, rand_id(), "R9 rnd complete");
                4: wr_reg(($urandom % 2) ? 12'h014 : 12'h018, $urandom, "R4 rnd trig");
                5: wr_reg(12'h000, {31'b0, ($urandom % 6) != 0}, "R2 rnd ctl");
                6: idle("R6 rnd idle");
                default: rd_reg(($urandom % 2) ? 12'h014 : 12'h0B0, "R11 rnd read");
            endcase
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule